// File: doc/BRIEF.md
# Dynamic Bus Sizing Master

This block is a bus master sequencer that moves byte, word and long-word operands over a 16-bit external data bus whose slaves may be either 8 or 16 bits wide. The master does not know a slave's width in advance. It opens a bus cycle, waits while the slave holds off, and learns the port width from the two-bit active-low acknowledge code that closes the cycle. It then runs as many further cycles as the operand needs. After each cycle the address moves on by the number of bytes just transferred.

On the front side a single request carries a size code, a byte address, 32 bits of write data and a direction. The block answers with a one-clock done pulse, an error flag and, for reads, the operand right-justified in a 32-bit word. Operands are big-endian: the byte at the lowest address is the most significant. Bytes are steered onto fixed data lanes. A 16-bit port uses lines 15..0, with the even byte on 15..8 and the odd byte on 7..0. An 8-bit port always sits on lines 15..8.

The acknowledge pair passes through a two-flop synchronizer before it is decoded. The address strobe is released between cycles until the synchronized acknowledge has returned to the negated code. A programmable timeout ends an operand whose slave never answers.

Top module: `dbs_master`

## Requirements
- R1: Acknowledge decode of `bus_ack_n[1:0]` (active low): `11` keeps the cycle open as a wait state, with address and strobe held; `10` (bit 0 asserted) ends the cycle as an 8-bit port; `01` (bit 1 asserted) ends it as a 16-bit port.
- R2: The reserved code `00` ends the cycle exactly as a 16-bit port does.
- R3: A long word at an even address to a 16-bit port takes two bus cycles, at the address and at the address plus 2. The first half is kept and the second half is fetched next.
- R4: With an 8-bit port, every cycle moves one byte on lines 15..8 and the address advances by 1. An n-byte operand takes n cycles.
- R5: On a 16-bit port, a byte at an even address uses lines 15..8 and is written with `bus_uwe_n` low. A byte at an odd address uses lines 7..0 and is written with `bus_lwe_n` low. Both enables stay high on reads and outside a strobe. An operand starting at an odd address costs one extra single-byte cycle.
- R6: Operands are big-endian. The byte at the request address is the most significant byte of the operand. Read data is right-justified in `rdata`.
- R7: Size code `req_size`: `00` byte, `01` word, `10` long word. The code `11` is handled as a long word.
- R8: `done` is a one-clock pulse after the final cycle of an operand, and `rdata` is valid in that same clock.
- R9: If the acknowledge stays at `11` for `timeout_lim`+1 clocks of a strobe, the strobe is released and `done` pulses with `err` high.
- R10: The acknowledge is synchronized through two flops. With no wait states each strobe lasts 3 clocks plus the number of wait states the slave inserts. The strobe is high for at least two clocks between consecutive cycles.
- R11: A request is taken only while `busy` is low. A `req_valid` raised during an operand is ignored and is not queued.
- R12: After reset, `busy`, `done` and `err` are low, and `bus_as_n`, `bus_uwe_n` and `bus_lwe_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operand request, taken when idle |
| req_size | input | 2 | Operand size code |
| req_addr | input | AW | Operand byte address |
| req_wdata | input | 32 | Write operand, right-justified |
| req_write | input | 1 | 1 = write, 0 = read |
| timeout_lim | input | TW | Wait clocks allowed before the timeout fires |
| busy | output | 1 | Operand in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| rdata | output | 32 | Assembled read operand |
| bus_addr | output | AW | Bus byte address |
| bus_rd | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_dout | output | 16 | Write data lanes |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_uwe_n | output | 1 | Upper-lane write enable, active low |
| bus_lwe_n | output | 1 | Lower-lane write enable, active low |
| bus_din | input | 16 | Read data lanes |
| bus_ack_n | input | 2 | Acknowledge and port-width code, active low |

## Verification
The assertions take three things for granted. A slave answers only while the strobe is low and releases its code to `11` once the strobe rises. `timeout_lim` does not change during an operand. The request inputs are stable for the clock in which they are taken. The bench slave model follows these rules exactly: it drives the code after its programmed wait states, holds it until the strobe rises and then returns it to `11`. The bench changes the timeout limit only between operands, and it moves request inputs only on falling clock edges.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  localparam int OPW    = 32;
  localparam int LANE_W = 16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } opsize_e;

  typedef enum logic [1:0] {
    PW_WAIT = 2'd0,
    PW_8    = 2'd1,
    PW_16   = 2'd2
  } portw_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GAP    = 2'd1,
    ST_ACTIVE = 2'd2
  } seq_state_e;

  // bytes in an operand for a size code; reserved code counts as long
  function automatic logic [2:0] op_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dbs_ack_sync.sv
module dbs_ack_sync
  import dbs_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   ack_n_in,
  output portw_e       width
);

  logic [1:0] stage_q [STAGES];
  logic [1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = ack_n_in;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= 2'b11;
    end else begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
    end
  end

  // active-low code: 11 wait, 10 byte port, 01 and 00 halfword port
  always_comb begin
    case (stage_q[STAGES-1])
      2'b11:   width = PW_WAIT;
      2'b10:   width = PW_8;
      default: width = PW_16;
    endcase
  end

endmodule

// File: rtl/dbs_lane_steer.sv
module dbs_lane_steer
  import dbs_pkg::*;
(
  input  logic              active,
  input  logic              write,
  input  logic              addr_odd,
  input  logic              rem_one,
  input  logic [7:0]        hi_byte,
  input  logic [7:0]        lo_byte,
  input  portw_e            width,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout,
  output logic              uwe_n,
  output logic              lwe_n,
  output logic              take_two,
  output logic [7:0]        rd_b0,
  output logic [7:0]        rd_b1
);

  logic pair_slot;

  // two bytes fit only when the current address is even and two remain
  assign pair_slot = !addr_odd && !rem_one;

  // a single byte is mirrored on both lanes so either port width sees it
  assign dout  = pair_slot ? {hi_byte, lo_byte} : {hi_byte, hi_byte};
  assign uwe_n = !(active && write && !addr_odd);
  assign lwe_n = !(active && write && (addr_odd || !rem_one));

  assign take_two = (width == PW_16) && pair_slot;
  assign rd_b0    = ((width == PW_16) && addr_odd) ? din[7:0] : din[15:8];
  assign rd_b1    = din[7:0];

endmodule

// File: rtl/dbs_rd_assemble.sv
module dbs_rd_assemble
  import dbs_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           cap,
  input  logic           cap_two,
  input  logic [2:0]     rem,
  input  logic [7:0]     b0,
  input  logic [7:0]     b1,
  output logic [OPW-1:0] data_q
);

  logic [OPW-1:0] data_d;
  logic [2:0]     pos0;
  logic [2:0]     pos1;
  logic           load_en;

  // byte positions counted from the least significant end of the operand
  assign pos0    = rem - 3'd1;
  assign pos1    = rem - 3'd2;
  assign load_en = clr || cap;

  always_comb begin
    data_d = data_q;
    if (clr) begin
      data_d = '0;
    end else if (cap) begin
      data_d[{pos0[1:0], 3'b000} +: 8] = b0;
      if (cap_two) data_d[{pos1[1:0], 3'b000} +: 8] = b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (load_en) data_q <= data_d;
  end

  AST_PAIR_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && cap_two) |-> (rem >= 3'd2)); // R3

  AST_CAP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> (rem != 3'd0)); // R6

endmodule

// File: rtl/dbs_master.sv
module dbs_master
  import dbs_pkg::*;
#(
  parameter int AW = 24,
  parameter int TW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_size,
  input  logic [AW-1:0]     req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              req_write,
  input  logic [TW-1:0]     timeout_lim,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdata,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_rd,
  output logic              bus_as_n,
  output logic [15:0]       bus_dout,
  output logic              bus_dout_en,
  output logic              bus_uwe_n,
  output logic              bus_lwe_n,
  input  logic [15:0]       bus_din,
  input  logic [1:0]        bus_ack_n
);

  seq_state_e        state_q, state_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [2:0]        rem_q, rem_d;
  logic [OPW-1:0]    wdata_q;
  logic              write_q;
  logic [TW-1:0]     tmr_q, tmr_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  portw_e            width;
  logic              active;
  logic              accept;
  logic              cycle_end;
  logic              tmo;
  logic              take_two;
  logic              last;
  logic [2:0]        step;
  logic [2:0]        rem_m1;
  logic [2:0]        rem_m2;
  logic [7:0]        hi_byte;
  logic [7:0]        lo_byte;
  logic [7:0]        rd_b0;
  logic [7:0]        rd_b1;
  logic              op_load_en;

  dbs_ack_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_n_in (bus_ack_n),
    .width    (width)
  );

  assign active = (state_q == ST_ACTIVE);
  assign rem_m1 = rem_q - 3'd1;
  assign rem_m2 = rem_q - 3'd2;
  assign hi_byte = wdata_q[{rem_m1[1:0], 3'b000} +: 8];
  assign lo_byte = wdata_q[{rem_m2[1:0], 3'b000} +: 8];

  dbs_lane_steer u_lane (
    .active   (active),
    .write    (write_q),
    .addr_odd (addr_q[0]),
    .rem_one  (rem_q == 3'd1),
    .hi_byte  (hi_byte),
    .lo_byte  (lo_byte),
    .width    (width),
    .din      (bus_din),
    .dout     (bus_dout),
    .uwe_n    (bus_uwe_n),
    .lwe_n    (bus_lwe_n),
    .take_two (take_two),
    .rd_b0    (rd_b0),
    .rd_b1    (rd_b1)
  );

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign cycle_end = active && (width != PW_WAIT);
  assign tmo       = active && (width == PW_WAIT) && (tmr_q == timeout_lim);
  assign step      = take_two ? 3'd2 : 3'd1;
  assign last      = (rem_q == step);

  dbs_rd_assemble u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .cap     (cycle_end && !write_q),
    .cap_two (take_two),
    .rem     (rem_q),
    .b0      (rd_b0),
    .b1      (rd_b1),
    .data_q  (rdata)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    tmr_d   = tmr_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_GAP;
          addr_d  = req_addr;
          rem_d   = op_bytes(req_size);
        end
      end
      ST_GAP: begin
        // reopen only once the previous acknowledge has cleared the synchronizer
        if (width == PW_WAIT) begin
          state_d = ST_ACTIVE;
          tmr_d   = '0;
        end
      end
      ST_ACTIVE: begin
        if (cycle_end) begin
          addr_d  = addr_q + AW'(step);
          rem_d   = rem_q - step;
          state_d = last ? ST_IDLE : ST_GAP;
          done_d  = last;
        end else if (tmo) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_d   = 1'b1;
        end else begin
          tmr_d = tmr_q + TW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign op_load_en = accept;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      tmr_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      tmr_q   <= tmr_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      write_q <= 1'b0;
    end else if (op_load_en) begin
      wdata_q <= req_wdata;
      write_q <= req_write;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign err         = err_q;
  assign bus_addr    = addr_q;
  assign bus_rd      = !write_q;
  assign bus_as_n    = !active;
  assign bus_dout_en = active && write_q;

  AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && width == PW_WAIT) |=> $stable(bus_addr)); // R1

  AST_GAP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> bus_as_n); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R9

  AST_WE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_uwe_n || !bus_lwe_n) |-> (!bus_as_n && !bus_rd)); // R5

  AST_START_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid)); // R11

endmodule

// File: tb/dbs_master_test.sv
`timescale 1ns/1ps
module dbs_master_test;
  localparam int AW = 24;
  localparam int TW = 8;
  localparam int NV = 14;

  // entry: {write, size[1:0], port16, both_code, waits[1:0], addr[5:0]}
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 2'b10, 1'b1, 1'b0, 2'd0, 6'd8 },
    {1'b0, 2'b10, 1'b0, 1'b0, 2'd1, 6'd12},
    {1'b0, 2'b01, 1'b1, 1'b0, 2'd0, 6'd5 },
    {1'b0, 2'b00, 1'b1, 1'b0, 2'd2, 6'd9 },
    {1'b0, 2'b00, 1'b1, 1'b0, 2'd0, 6'd10},
    {1'b1, 2'b10, 1'b1, 1'b0, 2'd1, 6'd16},
    {1'b1, 2'b10, 1'b0, 1'b0, 2'd0, 6'd20},
    {1'b1, 2'b01, 1'b1, 1'b0, 2'd0, 6'd25},
    {1'b1, 2'b00, 1'b1, 1'b0, 2'd0, 6'd31},
    {1'b0, 2'b10, 1'b1, 1'b1, 2'd0, 6'd34},
    {1'b1, 2'b01, 1'b1, 1'b1, 2'd0, 6'd40},
    {1'b0, 2'b11, 1'b1, 1'b0, 2'd0, 6'd44},
    {1'b0, 2'b10, 1'b1, 1'b0, 2'd3, 6'd49},
    {1'b1, 2'b10, 1'b0, 1'b0, 2'd1, 6'd51}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_size;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic          req_write;
  logic [TW-1:0] timeout_lim;
  logic          busy, done, err;
  logic [31:0]   rdata;
  logic [AW-1:0] bus_addr;
  logic          bus_rd, bus_as_n, bus_dout_en, bus_uwe_n, bus_lwe_n;
  logic [15:0]   bus_dout;
  logic [15:0]   bus_din;
  logic [1:0]    bus_ack_n;

  dbs_master #(.AW(AW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .timeout_lim(timeout_lim), .busy(busy), .done(done), .err(err),
    .rdata(rdata), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_as_n(bus_as_n),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_uwe_n(bus_uwe_n),
    .bus_lwe_n(bus_lwe_n), .bus_din(bus_din), .bus_ack_n(bus_ack_n)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // slave model state
  bit         s_p16, s_both, s_mute;
  int         s_waits;
  logic [7:0] mem [64];
  int         cyc_cnt, lowrun, gaprun, last_low, low_bad, min_gap, wcnt;

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 7 + 3) & 8'hff);
  endfunction

  initial begin
    bus_ack_n = 2'b11;
    bus_din   = '0;
    lowrun = 0; gaprun = 100; low_bad = 0; min_gap = 100; wcnt = 0; last_low = 0;
    forever begin
      @(negedge clk);
      if (rst_n && !bus_as_n) begin
        logic [5:0] a;
        a = bus_addr[5:0];
        if (lowrun == 0) begin
          cyc_cnt++;
          if (gaprun < min_gap) min_gap = gaprun;
        end
        lowrun++;
        bus_din = s_p16 ? {mem[{a[5:1], 1'b0}], mem[{a[5:1], 1'b1}]} : {mem[a], 8'h00};
        if (wcnt < s_waits) wcnt++;
        else if (!s_mute && bus_ack_n == 2'b11) begin
          if (!bus_rd) begin
            if (s_p16) begin
              if (!bus_uwe_n) mem[{a[5:1], 1'b0}] = bus_dout[15:8];
              if (!bus_lwe_n) mem[{a[5:1], 1'b1}] = bus_dout[7:0];
            end else begin
              mem[a] = bus_dout[15:8];
            end
          end
          bus_ack_n = s_p16 ? (s_both ? 2'b00 : 2'b01) : 2'b10;
        end
      end else begin
        if (lowrun > 0) begin
          last_low = lowrun;
          if (!s_mute && lowrun != 3 + s_waits) low_bad++;
          lowrun = 0;
          gaprun = 0;
        end
        gaprun++;
        wcnt = 0;
        bus_ack_n = 2'b11;
      end
    end
  end

  task automatic run_op(input bit wr, input logic [1:0] sz, input logic [5:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output bit er);
    bit ok;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_addr = {{(AW-6){1'b0}}, a}; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    ok = 1'b0;
    for (int t = 0; t < 3000; t++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    rd = rdata;
    er = err;
    check(ok, "R8", "done seen before watchdog", {31'b0, ok}, 32'd1);
    @(negedge clk);
    check(done == 1'b0, "R8", "done lasts one clock", {31'b0, done}, 32'd0);
  endtask

  function automatic int exp_cycles(input bit p16, input int n, input int a);
    if (!p16) return n;
    if (a % 2 == 1) return 1 + n / 2;
    return (n + 1) / 2;
  endfunction

  initial begin
    #600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [31:0] rd, expv, wd;
    bit er;
    rst_n = 1'b0; req_valid = 1'b0; req_size = '0; req_addr = '0;
    req_wdata = '0; req_write = 1'b0; timeout_lim = 8'd50;
    s_p16 = 1'b1; s_both = 1'b0; s_mute = 1'b0; s_waits = 0; cyc_cnt = 0;
    for (int k = 0; k < 64; k++) mem[k] = pat(k);
    repeat (4) @(negedge clk);
    // R12 reset state
    check(busy == 0 && done == 0 && err == 0, "R12", "reset flags",
          {29'b0, busy, done, err}, 32'd0);
    check(bus_as_n && bus_uwe_n && bus_lwe_n, "R12", "reset strobes",
          {29'b0, bus_as_n, bus_uwe_n, bus_lwe_n}, 32'd7);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0 && bus_as_n, "R12", "idle after release",
          {30'b0, busy, bus_as_n}, 32'd1);

    for (int v = 0; v < NV; v++) begin
      logic [12:0] e;
      bit wr, p16, both;
      logic [1:0] sz;
      int n, a, ec;
      string tag;
      e = VEC[v];
      wr = e[12]; sz = e[11:10]; p16 = e[9]; both = e[8];
      s_waits = int'(e[7:6]); a = int'(e[5:0]);
      n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
      tag = !p16 ? "R4" : both ? "R2" : (sz == 2'b11) ? "R7" : (n == 4) ? "R3" : "R5";
      s_p16 = p16; s_both = both;
      for (int k = 0; k < 64; k++) mem[k] = pat(k);
      wd = 32'h5A3C9600 + 32'(v) * 32'h01030507;
      cyc_cnt = 0;
      run_op(wr, sz, 6'(a), wd, rd, er);
      if (!wr) begin
        expv = '0;
        for (int i = 0; i < n; i++) expv = (expv << 8) | {24'b0, pat(a + i)};
        check(rd == expv, tag, "R6 read data", rd, expv);
      end else begin
        for (int i = 0; i < n; i++)
          check(mem[6'(a + i)] == wd[8*(n-1-i) +: 8], tag, "R6 written byte",
                {24'b0, mem[6'(a + i)]}, {24'b0, wd[8*(n-1-i) +: 8]});
        check(mem[6'(a - 1)] == pat(a - 1) && mem[6'(a + n)] == pat(a + n), tag,
              "neighbour bytes untouched", {16'b0, mem[6'(a - 1)], mem[6'(a + n)]},
              {16'b0, pat(a - 1), pat(a + n)});
      end
      ec = exp_cycles(p16, n, a);
      check(cyc_cnt == ec, tag, "bus cycle count", 32'(cyc_cnt), 32'(ec));
      check(er == 1'b0, tag, "no error", {31'b0, er}, 32'd0);
    end

    // R1 R10 strobe length per cycle and gap between cycles
    check(low_bad == 0, "R10", "R1 strobe length equals 3 plus waits", 32'(low_bad), 32'd0);
    check(min_gap >= 2, "R10", "strobe gap between cycles", 32'(min_gap), 32'd2);

    // R9 timeout with a silent slave
    s_mute = 1'b1; s_waits = 0; s_p16 = 1'b1; timeout_lim = 8'd5;
    run_op(1'b0, 2'b01, 6'd2, 32'h0, rd, er);
    check(er == 1'b1, "R9", "timeout error flag", {31'b0, er}, 32'd1);
    check(last_low == 6, "R9", "strobe clocks before timeout", 32'(last_low), 32'd6);
    check(bus_as_n && !busy, "R9", "bus released", {30'b0, bus_as_n, busy}, 32'd2);
    s_mute = 1'b0; timeout_lim = 8'd50;

    // R11 request during an operand is ignored
    for (int k = 0; k < 64; k++) mem[k] = pat(k);
    s_p16 = 1'b1; s_both = 1'b0; s_waits = 2; cyc_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'b10;
    req_addr = '0; req_wdata = 32'hCAFEF00D;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    req_valid = 1'b1; req_addr = {{(AW-6){1'b0}}, 6'd60}; req_wdata = 32'h01020304;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < 3000 && !done; t++) @(negedge clk);
    repeat (20) @(negedge clk);
    check(busy == 1'b0, "R11", "no queued operand", {31'b0, busy}, 32'd0);
    check(cyc_cnt == 2, "R11", "only first operand ran", 32'(cyc_cnt), 32'd2);
    check({mem[60], mem[61], mem[62], mem[63]} == {pat(60), pat(61), pat(62), pat(63)},
          "R11", "ignored request wrote nothing", {mem[60], mem[61], mem[62], mem[63]},
          {pat(60), pat(61), pat(62), pat(63)});
    check({mem[0], mem[1], mem[2], mem[3]} == 32'hCAFEF00D, "R11", "first operand written",
          {mem[0], mem[1], mem[2], mem[3]}, 32'hCAFEF00D);

    summary();
  end

endmodule